// File: doc/BRIEF.md
# Two-Byte Four-Operation Register Processor

This block is a small stored-program processor core. Program bytes and data bytes live in one shared synchronous memory reached through a single byte-wide port. The core never executes out of memory directly. It copies each instruction into internal holding registers first, then decodes it and carries it out. A ring of stage flip-flops sequences this work, with exactly one stage active at a time. The datapath is a four-entry register bank feeding an 8-bit ripple-carry adder.

Every instruction takes two consecutive bytes. The first byte carries the operation code in bits [7:6], the destination register `rd` in bits [5:4] and the source register `rs` in bits [3:2]. The second byte carries either a constant or a memory address. The core runs only while `run` is high. When `run` drops, the core completes the instruction in flight, then parks with `halt` high until `run` returns. Debug outputs expose the program counter and all four registers.

Top module: `byte_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `halt` is 1, `dbg_pc` is 0, every register reads 0, and both `mem_re` and `mem_we` are 0.
- R2: The instruction cycle has four fetch cycles followed by one execute cycle.
  - Fetch: read the byte at PC, wait one cycle for the read data, capture it and add 1 to PC, then do the same for the second byte.
  - Execute: load uses one more cycle after execute to capture the read data.
  - The next instruction's fetch starts on the cycle that follows, and PC wraps modulo 256.
- R3: Opcode 00 (load) writes the memory byte at the address in the second byte into `rd`.
- R4: Opcode 01 (store) raises `mem_we` for exactly one cycle, with `mem_addr` set to the second byte and `mem_wdata` set to `rd`.
- R5: Opcode 10 (add constant) replaces `rd` with its old value plus the second byte. For example, 7 plus 4 gives 11.
- R6: Opcode 11 (register add) replaces `rd` with `rd` plus `rs` and leaves `rs` unchanged, unless `rs` is the same register as `rd`, in which case the value doubles.
- R7: Sums are 8 bits wide, and the carry out of bit 7 is dropped. For example, 0xFB plus 0x10 gives 0x0B.
- R8: `run` is sampled only in the idle stage and on the last cycle of an instruction.
  - If `run` is low at that point, the core enters idle with `halt` high.
  - While idle, PC and registers hold, and no memory access happens.
  - When `run` rises again, fetching resumes at the held PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows instruction execution while high |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Store data |
| mem_re | output | 1 | Read enable |
| mem_we | output | 1 | Write enable |
| halt | output | 1 | Core is idle |
| dbg_pc | output | 8 | Program counter |
| dbg_regs | output | 32 | Registers r3..r0, with r0 in bits [7:0] |

## Verification
The bench drops `run` partway through an instruction.
- A core that stopped at once would leave PC on an odd byte.
- A core that ignored `run` would keep fetching.

The program covers several corner cases:
- An add that overflows past 255, which a design with a wide sum or a kept carry would get wrong.
- A register added to itself, which a design that read `rs` after writing `rd` would get wrong.
- A store followed by a load of the same byte, which a design with an off-by-one read latency would load as stale or fetch data.

A reference model compares PC, `halt`, `mem_we` and all four registers against the design on every cycle. This exposes mistimed stages and write strobes that last two cycles.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int NSTG = 7;
  localparam int ST_IDLE = 0;
  localparam int ST_FOP  = 1;
  localparam int ST_LOP  = 2;
  localparam int ST_FARG = 3;
  localparam int ST_LARG = 4;
  localparam int ST_EXEC = 5;
  localparam int ST_LDW  = 6;

  typedef enum logic [1:0] {
    OPC_LOAD  = 2'b00,
    OPC_STORE = 2'b01,
    OPC_ADDK  = 2'b10,
    OPC_ADDR  = 2'b11
  } opc_e;
endpackage

// File: rtl/rca_adder.sv
module rca_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i] ^ c[i];
    if (i < W-1) begin : g_carry
      assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int NREG = 4,
  parameter int W    = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_sel,
  input  logic [W-1:0]      wr_val,
  input  logic [RW-1:0]     rd_sel_a,
  input  logic [RW-1:0]     rd_sel_b,
  output logic [W-1:0]      rd_val_a,
  output logic [W-1:0]      rd_val_b,
  output logic [NREG*W-1:0] flat
);
  logic [W-1:0] cells [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[k] <= '0;
      end else if (wr_en && wr_sel == RW'(k)) begin
        cells[k] <= wr_val;
      end
    end
    assign flat[k*W +: W] = cells[k];
  end

  assign rd_val_a = cells[rd_sel_a];
  assign rd_val_b = cells[rd_sel_b];
endmodule

// File: rtl/step_ring.sv
module step_ring
  import core_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            is_load,
  output logic [NSTG-1:0] stg
);
  localparam logic [NSTG-1:0] STG_RST = NSTG'(1) << ST_IDLE;

  logic [NSTG-1:0] nxt;
  logic            last;

  always_comb begin
    last          = (stg[ST_EXEC] & ~is_load) | stg[ST_LDW];
    nxt           = '0;
    nxt[ST_IDLE]  = (stg[ST_IDLE] | last) & ~run;
    nxt[ST_FOP]   = (stg[ST_IDLE] | last) & run;
    nxt[ST_LOP]   = stg[ST_FOP];
    nxt[ST_FARG]  = stg[ST_LOP];
    nxt[ST_LARG]  = stg[ST_FARG];
    nxt[ST_EXEC]  = stg[ST_LARG];
    nxt[ST_LDW]   = stg[ST_EXEC] & is_load;
  end

  always_ff @(posedge clk) begin
    if (rst) stg <= STG_RST;
    else     stg <= nxt;
  end
endmodule

// File: rtl/byte_core.sv
module byte_core
  import core_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              halt,
  output logic [AW-1:0]     dbg_pc,
  output logic [NREG*DW-1:0] dbg_regs
);
  localparam int RW = $clog2(NREG);
  localparam int HW = 2 + 2*RW;

  logic [NSTG-1:0] stg;
  logic [AW-1:0]   pc_q;
  logic [HW-1:0]   ir_hdr;
  logic [DW-1:0]   ir_arg;
  opc_e            opc;
  logic [RW-1:0]   rd_f, rs_f;
  logic [DW-1:0]   rd_v, rs_v, addend, sum;
  logic            is_load, rf_we;
  logic [DW-1:0]   rf_wval;

  assign opc     = opc_e'(ir_hdr[HW-1 -: 2]);
  assign rd_f    = ir_hdr[HW-3 -: RW];
  assign rs_f    = ir_hdr[RW-1:0];
  assign is_load = (opc == OPC_LOAD);

  step_ring u_ring (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .is_load (is_load),
    .stg     (stg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ir_hdr <= '0;
      ir_arg <= '0;
    end else begin
      if (stg[ST_LOP])  ir_hdr <= mem_rdata[DW-1 -: HW];
      if (stg[ST_LARG]) ir_arg <= mem_rdata;
      if (stg[ST_LOP] || stg[ST_LARG]) pc_q <= pc_q + AW'(1);
    end
  end

  assign addend = (opc == OPC_ADDK) ? ir_arg : rs_v;

  rca_adder #(.W(DW)) u_add (
    .a (rd_v),
    .b (addend),
    .s (sum)
  );

  assign rf_we   = (stg[ST_EXEC] && (opc == OPC_ADDK || opc == OPC_ADDR)) || stg[ST_LDW];
  assign rf_wval = stg[ST_LDW] ? mem_rdata : sum;

  reg_bank #(.NREG(NREG), .W(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rf_we),
    .wr_sel   (rd_f),
    .wr_val   (rf_wval),
    .rd_sel_a (rd_f),
    .rd_sel_b (rs_f),
    .rd_val_a (rd_v),
    .rd_val_b (rs_v),
    .flat     (dbg_regs)
  );

  always_comb begin
    mem_addr  = (stg[ST_FOP] || stg[ST_FARG]) ? pc_q : ir_arg[AW-1:0];
    mem_re    = stg[ST_FOP] || stg[ST_FARG] || (stg[ST_EXEC] && is_load);
    mem_we    = stg[ST_EXEC] && (opc == OPC_STORE);
    mem_wdata = rd_v;
  end

  assign halt   = stg[ST_IDLE];
  assign dbg_pc = pc_q;
endmodule

module core_chk
  import core_pkg::*;
#(
  parameter int AW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic            halt,
  input logic            mem_re,
  input logic            mem_we,
  input logic [AW-1:0]   pc,
  input logic [NSTG-1:0] stg
);
  // R2
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(stg) == 1);

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!mem_re && !mem_we));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !run) |=> (halt && $stable(pc)));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> (pc == $past(pc) + AW'(1)));
endmodule

bind byte_core core_chk #(.AW(AW)) u_core_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .halt   (halt),
  .mem_re (mem_re),
  .mem_we (mem_we),
  .pc     (dbg_pc),
  .stg    (stg)
);

// File: tb/tb_byte_core.sv
module tb_byte_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_addr, mem_wdata, dbg_pc;
  logic        mem_re, mem_we, halt;
  logic [31:0] dbg_regs;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit live   = 0;

  always #10 clk = ~clk;

  byte_core dut (
    .clk(clk), .rst(rst), .run(run), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .halt(halt), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  // reference model
  logic [7:0] mm [256];
  int m_step = 0;
  int m_pc = 0;
  int m_r [4];
  int m_op = 0, m_arg = 0;
  string m_tag = "R1";

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_finish();
    m_step = run ? 1 : 0;
  endtask

  task automatic m_tick();
    int rd, rs;
    rd = (m_op >> 4) & 3;
    rs = (m_op >> 2) & 3;
    case (m_step)
      0: if (run) m_step = 1;
      1: m_step = 2;
      2: begin m_op = mm[m_pc]; m_pc = (m_pc + 1) % 256; m_step = 3; end
      3: m_step = 4;
      4: begin m_arg = mm[m_pc]; m_pc = (m_pc + 1) % 256; m_step = 5; end
      5: begin
        case ((m_op >> 6) & 3)
          0: m_step = 6;
          1: begin mm[m_arg] = 8'(m_r[rd]); m_tag = "R4"; m_finish(); end
          2: begin m_r[rd] = (m_r[rd] + m_arg) % 256; m_tag = "R5"; m_finish(); end
          default: begin m_r[rd] = (m_r[rd] + m_r[rs]) % 256; m_tag = "R6"; m_finish(); end
        endcase
      end
      default: begin m_r[rd] = mm[m_arg]; m_tag = "R3"; m_finish(); end
    endcase
  endtask

  always @(posedge clk) if (!rst) m_tick();

  always @(negedge clk) begin
    if (live && !done) begin
      check("R8", int'(halt), int'(m_step == 0));
      check("R2", int'(dbg_pc), m_pc);
      check("R4", int'(mem_we), int'(m_step == 5 && ((m_op >> 6) & 3) == 1));
      for (int i = 0; i < 4; i++) check(m_tag, int'(dbg_regs[i*8 +: 8]), m_r[i]);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    finish_run();
  end

  initial begin
    static byte unsigned prog [20] = '{
      8'hB0, 8'h07,   // addn r3,7
      8'hB0, 8'h04,   // addn r3,4 -> 11
      8'h10, 8'h80,   // load r1,[80]
      8'hDC, 8'h00,   // add r1,r3 -> FB
      8'h90, 8'h10,   // addn r1,10 -> 0B (carry dropped)
      8'h50, 8'h81,   // store r1,[81]
      8'hCC, 8'h00,   // add r0,r3 -> 11
      8'hFC, 8'h00,   // add r3,r3 -> 22
      8'h70, 8'h82,   // store r3,[82]
      8'h20, 8'h81    // load r2,[81]
    };
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    for (int i = 0; i < 20; i++) ram[i] = prog[i];
    ram[8'h80] = 8'hF0;
    for (int i = 0; i < 256; i++) mm[i] = ram[i];
    for (int i = 0; i < 4; i++) m_r[i] = 0;

    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", int'(halt), 1);
    check("R1", int'(dbg_pc), 0);
    check("R1", int'(dbg_regs), 0);
    check("R1", int'(mem_re | mem_we), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(halt), 1);
    check("R1", int'(mem_re), 0);
    live = 1;
    repeat (3) @(negedge clk);
    run = 1'b1;
    repeat (23) @(negedge clk);
    run = 1'b0;                 // R8: drop mid-instruction
    repeat (15) @(negedge clk);
    check("R8", int'(halt), 1);
    check("R8", int'(dbg_pc[0]), 0);
    run = 1'b1;
    repeat (300) @(negedge clk);
    run = 1'b0;
    repeat (20) @(negedge clk);
    check("R8", int'(halt), 1);
    check("R4", int'(ram[8'h81]), 8'h0B);
    check("R7", int'(ram[8'h81]), int'(mm[8'h81]));
    check("R6", int'(ram[8'h82]), 8'h16);
    check("R7", int'(dbg_regs[15:8]), 8'h0B);
    check("R3", int'(dbg_regs[23:16]), 8'h0B);
    check("R6", int'(dbg_regs[31:24]), 8'h16);
    check("R3", int'(dbg_regs[7:0]), 8'hB0);
    check("R5", int'(ram[8'h82]), int'(mm[8'h82]));
    finish_run();
  end
endmodule